// File: doc/BRIEF.md
# Packet Receive FIFO with Per-Packet Status Tracking

This block buffers the output of a serial frame deframer for a microcontroller. Each deframed data byte is written into a byte-wide queue. At the end of every accepted frame the deframer writes one status byte, which is stored directly after that frame's data and marked by a tag bit. Several complete packets, each closed by its status byte, can be held at the same time, together with the start of the next packet.

The microcontroller drains the queue one entry per read strobe. A count output tells it how many data bytes it must read before it reaches the next stored status byte. When no status byte is stored, the count gives the number of bytes of the unfinished packet still held. One entry is always kept in reserve. When a data byte arrives and only that reserve is left, the byte is dropped and an overrun flag is raised toward the deframer. The deframer is expected to close the frame. Its status byte then takes the reserved slot with the overrun bit forced on.

The depth is a parameter. Because the tag of the entry at the read pointer is predicted from the per-packet length queue, the bench and the assertions can check that prediction against the stored tag bit.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, `fifo_empty` is 1, `next_cnt` is 0, `overrun` is 0 and `rd_byte`/`rd_is_stat` are 0.
- R2: Entries are read back in write order. `rd_byte` and `rd_is_stat` show the entry taken by a `rd_stb` in the cycle after the strobe, and hold until the next strobe. `fifo_empty` is 1 exactly when no entry is stored.
- R3: A status write stores its byte after the data bytes of the current packet, with `rd_is_stat`=1 when read (data bytes read with `rd_is_stat`=0). Several closed packets may be stored at once.
- R4: While at least one status byte is stored, `next_cnt` equals the number of data bytes stored ahead of the oldest stored status byte.
- R5: While no status byte is stored, `next_cnt` equals the number of stored data bytes of the unfinished packet.
- R6: A data write is stored only while fewer than DEPTH-1 entries are held. Otherwise the byte is dropped and `overrun` is 1 from the next cycle until a status write.
- R7: A status write is stored while fewer than DEPTH entries are held, with bit 7 forced to 1 if `overrun` was set. Every status write clears `overrun`.
- R8: A `rd_stb` on an empty FIFO returns `rd_byte`=0 and `rd_is_stat`=0 and changes no stored state.
- R9: When `stat_valid` and `wr_valid` are both 1 in one cycle, only the status byte is taken and the data byte is ignored.
- R10: `flush` is synchronous and overrides every other input: from the next cycle the FIFO is empty, `next_cnt` is 0, `overrun` is 0 and `rd_byte`/`rd_is_stat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous empty of all contents and counters |
| wr_valid | input | 1 | Deframer data byte write strobe |
| wr_byte | input | 8 | Deframer data byte |
| stat_valid | input | 1 | Deframer end-of-frame status write strobe |
| stat_byte | input | 8 | Status byte (bit 7 is the overrun bit) |
| rd_stb | input | 1 | Microcontroller read strobe |
| rd_byte | output | 8 | Byte taken by the last read strobe |
| rd_is_stat | output | 1 | 1 when the last entry read was a status byte |
| next_cnt | output | $clog2(DEPTH+1) | Data bytes before the next status byte, or partial packet size |
| fifo_empty | output | 1 | No entry stored |
| overrun | output | 1 | A data byte was dropped, so the frame must be closed |

## Verification
Directed packets of different lengths, including zero-length frames, are stacked so that `next_cnt` must switch between the oldest-packet count and the partial-packet count as status bytes are written and read. A run that writes past the reserve separates a correct drop-and-flag from a design that overwrites data or loses the status slot, and the read-back of the status byte shows whether bit 7 was forced. Simultaneous data and status strobes, reads of an empty FIFO, and a flush with packets present each isolate one priority rule. A long seeded random mix of writes, status writes, reads and rare flushes is then compared entry by entry with a queue model, with read pressure alternating so that the queue spends time both near full and near empty.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;
  // One stored entry: tag bit plus byte.
  typedef struct packed {
    logic       is_stat;
    logic [7:0] byte_v;
  } fifo_ent_t;
endpackage

// File: rtl/prf_store.sv
module prf_store
  import pkt_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  fifo_ent_t     wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output fifo_ent_t     rdata
);
  // Simple dual-port memory with a registered read port.
  fifo_ent_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/prf_lenq.sv
module prf_lenq #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [CW-1:0] push_len,
  input  logic          pop,
  output logic [CW-1:0] head_len,
  output logic          nonempty
);
  localparam int QAW = $clog2(DEPTH);

  logic [CW-1:0]  lens [DEPTH];
  logic [QAW-1:0] hd, tl;
  logic [QAW:0]   n;

  always_ff @(posedge clk) begin
    if (push) lens[tl] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hd <= '0;
      tl <= '0;
      n  <= '0;
    end else begin
      if (push) tl <= (tl == QAW'(DEPTH - 1)) ? '0 : tl + QAW'(1);
      if (pop)  hd <= (hd == QAW'(DEPTH - 1)) ? '0 : hd + QAW'(1);
      n <= n + (QAW+1)'(push) - (QAW+1)'(pop);
    end
  end

  assign head_len = lens[hd];
  assign nonempty = (n != '0);

  // R3: a status read only happens while a packet length is queued
  a_r3_pop_has_entry: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);
  // R3: never more closed packets than storage entries
  a_r3_len_room: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (int'(n) < DEPTH));
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_valid,
  input  logic [7:0]    wr_byte,
  input  logic          stat_valid,
  input  logic [7:0]    stat_byte,
  input  logic          rd_stb,
  output logic [7:0]    rd_byte,
  output logic          rd_is_stat,
  output logic [CW-1:0] next_cnt,
  output logic          fifo_empty,
  output logic          overrun
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] wp, rp;
  logic [CW-1:0] occ, wr_part, consumed;
  logic          ovr_q, rd_hit_q, pred_stat_q;
  logic [CW-1:0] q_head;
  logic          q_ne;
  fifo_ent_t     wdata, mem_q;

  // Accept / drop decisions from the state before the edge.
  logic rd_ok, head_is_stat, stat_ok, data_ok, data_drop, we;
  always_comb begin
    rd_ok        = rd_stb && (occ != '0) && !flush;
    head_is_stat = q_ne && (q_head == consumed);
    stat_ok      = stat_valid && (occ < CW'(DEPTH)) && !flush;
    data_ok      = wr_valid && !stat_valid && (occ < CW'(DEPTH - 1)) && !flush;
    data_drop    = wr_valid && !stat_valid && !(occ < CW'(DEPTH - 1)) && !flush;
    we           = stat_ok || data_ok;
    if (stat_ok) wdata = '{is_stat: 1'b1, byte_v: stat_byte | {ovr_q, 7'b0}};
    else         wdata = '{is_stat: 1'b0, byte_v: wr_byte};
  end

  prf_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .we(we), .waddr(wp), .wdata(wdata),
    .re(rd_ok), .raddr(rp), .rdata(mem_q)
  );

  prf_lenq #(.DEPTH(DEPTH), .CW(CW)) lenq_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push(stat_ok), .push_len(wr_part),
    .pop(rd_ok && head_is_stat),
    .head_len(q_head), .nonempty(q_ne)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp          <= '0;
      rp          <= '0;
      occ         <= '0;
      wr_part     <= '0;
      consumed    <= '0;
      ovr_q       <= 1'b0;
      rd_hit_q    <= 1'b0;
      pred_stat_q <= 1'b0;
    end else begin
      if (we)    wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      occ <= occ + CW'(we) - CW'(rd_ok);

      if (stat_ok)      wr_part <= '0;
      else if (data_ok) wr_part <= wr_part + CW'(1);

      if (rd_ok) consumed <= head_is_stat ? '0 : consumed + CW'(1);

      if (stat_valid)     ovr_q <= 1'b0;
      else if (data_drop) ovr_q <= 1'b1;

      if (rd_stb) begin
        rd_hit_q    <= rd_ok;
        pred_stat_q <= rd_ok && head_is_stat;
      end
    end
  end

  assign rd_byte    = rd_hit_q ? mem_q.byte_v : 8'h00;
  assign rd_is_stat = rd_hit_q && mem_q.is_stat;
  assign next_cnt   = q_ne ? (q_head - consumed) : (wr_part - consumed);
  assign fifo_empty = (occ == '0);
  assign overrun    = ovr_q;

  // R2: stored entries never exceed the memory depth
  a_r2_occ_bound: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);
  // R3: tag predicted from length queue matches the stored tag bit
  a_r3_tag_agree: assert property (@(posedge clk) disable iff (rst)
    rd_hit_q |-> (mem_q.is_stat == pred_stat_q));
  // R4: the count never claims more bytes than are stored
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    next_cnt <= occ);
  // R6: a write with only the reserve left raises overrun
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !stat_valid && !flush && (int'(occ) >= DEPTH - 1)) |=> overrun);
  // R7: a status write clears the overrun flag
  a_r7_ovr_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !flush) |=> !overrun);
  // R8: an empty read returns zero
  a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && fifo_empty && !flush) |=> (rd_byte == 8'h00 && !rd_is_stat));
  // R10: flush empties everything
  a_r10_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fifo_empty && !overrun && next_cnt == '0 && !rd_is_stat));
endmodule

// File: tb/pkt_rx_fifo_tb_top.sv
module pkt_rx_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, wr_valid = 1'b0, stat_valid = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00, stat_byte = 8'h00;
  logic [7:0] rd_byte;
  logic rd_is_stat, fifo_empty, overrun;
  logic [CW-1:0] next_cnt;

  always #4 clk = ~clk;  // 125 MHz

  pkt_rx_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_valid(wr_valid), .wr_byte(wr_byte),
    .stat_valid(stat_valid), .stat_byte(stat_byte),
    .rd_stb(rd_stb), .rd_byte(rd_byte), .rd_is_stat(rd_is_stat),
    .next_cnt(next_cnt), .fifo_empty(fifo_empty), .overrun(overrun)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model: queue of {tag, byte}
  logic [8:0] mq[$];
  bit m_ovr = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cnt();
    int c = 0;
    foreach (mq[i]) begin
      if (mq[i][8]) return c;
      c++;
    end
    return c;
  endfunction

  function automatic bit has_stat();
    foreach (mq[i]) if (mq[i][8]) return 1'b1;
    return 1'b0;
  endfunction

  // Drive one cycle at a falling edge, update the model, check after the edge.
  task automatic step(input bit wv, input logic [7:0] wd, input bit sv,
                      input logic [7:0] sd, input bit rs, input bit fl);
    int occ0;
    logic [8:0] e_rd;
    e_rd = 9'h000;
    wr_valid = wv; wr_byte = wd; stat_valid = sv; stat_byte = sd;
    rd_stb = rs; flush = fl;
    occ0 = mq.size();
    if (fl) begin
      mq.delete();
      m_ovr = 1'b0;
    end else begin
      if (rs && occ0 > 0) e_rd = mq.pop_front();
      if (sv) begin
        if (occ0 < DEPTH) mq.push_back({1'b1, sd | (m_ovr ? 8'h80 : 8'h00)});
        m_ovr = 1'b0;
      end else if (wv) begin
        if (occ0 < DEPTH - 1) mq.push_back({1'b0, wd});
        else m_ovr = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; stat_valid = 1'b0; rd_stb = 1'b0; flush = 1'b0;
    if (has_stat()) chk("R4 count to next status", int'(next_cnt), exp_cnt());
    else            chk("R5 partial packet count", int'(next_cnt), exp_cnt());
    chk("R2 empty flag", int'(fifo_empty), int'(mq.size() == 0));
    chk("R6 overrun flag", int'(overrun), int'(m_ovr));
    if (rs || fl) begin
      if (fl)              chk("R10 read output after flush", int'(rd_byte), 0);
      else if (occ0 == 0)  chk("R8 empty read data", int'(rd_byte), 0);
      else if (e_rd[8])    chk("R7 status byte value", int'(rd_byte), int'(e_rd[7:0]));
      else                 chk("R2 data byte order", int'(rd_byte), int'(e_rd[7:0]));
      chk("R3 status tag", int'(rd_is_stat), int'(e_rd[8]));
    end
  endtask

  task automatic put_pkt(input int len, input logic [7:0] base, input logic [7:0] st);
    for (int i = 0; i < len; i++) step(1'b1, base + 8'(i), 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, st, 1'b0, 1'b0);
  endtask

  task automatic drain();
    while (mq.size() > 0) step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20231);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 empty after reset", int'(fifo_empty), 1);
    chk("R1 count after reset", int'(next_cnt), 0);
    chk("R1 overrun after reset", int'(overrun), 0);
    chk("R1 read data after reset", int'(rd_byte), 0);
    chk("R1 tag after reset", int'(rd_is_stat), 0);

    // R8 empty read changes nothing
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R8 still empty", int'(fifo_empty), 1);

    // R3/R4/R5: several packets resident plus a partial one
    put_pkt(3, 8'h10, 8'h47);
    put_pkt(2, 8'h20, 8'h40);
    put_pkt(0, 8'h00, 8'h41);
    step(1'b1, 8'h30, 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'h31, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R4 first packet length", int'(next_cnt), 3);
    drain();
    chk("R5 nothing left", int'(next_cnt), 0);

    // R5 partial read while still being written
    step(1'b1, 8'h50, 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'h51, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R5 partial after one read", int'(next_cnt), 1);
    step(1'b0, 8'h00, 1'b1, 8'h47, 1'b0, 1'b0);
    drain();

    // R6/R7 overrun: fill past the reserve, then close
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 8'(8'h60 + i), 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R6 overrun raised", int'(overrun), 1);
    chk("R6 reserve kept", int'(next_cnt), DEPTH - 1);
    step(1'b0, 8'h00, 1'b1, 8'h47, 1'b0, 1'b0);
    chk("R7 overrun cleared", int'(overrun), 0);
    // full now: another status is dropped
    step(1'b0, 8'h00, 1'b1, 8'h41, 1'b0, 1'b0);
    drain();

    // R9 simultaneous data and status: data ignored
    step(1'b1, 8'h70, 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'hAA, 1'b1, 8'h47, 1'b0, 1'b0);
    chk("R9 data ignored with status", int'(next_cnt), 1);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R9 status follows single byte", int'(rd_is_stat), 1);
    drain();

    // R10 flush with packets present
    put_pkt(4, 8'h80, 8'h47);
    step(1'b1, 8'h90, 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'h91, 1'b1, 8'h47, 1'b1, 1'b1);
    chk("R10 empty after flush", int'(fifo_empty), 1);
    chk("R10 count after flush", int'(next_cnt), 0);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      int rp;
      bit wv, sv, rs, fl;
      r  = int'($urandom % 100);
      rp = ((i / 400) % 2 == 1) ? 65 : 25;
      wv = (r < 55);
      sv = (r >= 55 && r < 66);
      rs = (int'($urandom % 100) < rp);
      fl = ($urandom % 500 == 0);
      step(wv, 8'($urandom), sv, 8'($urandom) & 8'h7F, rs, fl);
    end
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule